// File: doc/BRIEF.md
# Transfer Speed Downgrade Controller

This block watches a storage link for transmission-error events and lowers the transfer speed when those errors come too often. Each error arrives as a one-cycle pulse. The block counts the pulses over a sliding window that is timed by a slow tick input. The window is a ring of per-interval counters: when an interval expires, its errors drop out of the total, so no single boundary wipes the whole history.

When the windowed count goes above a threshold, the block moves the link down one rung of a fixed ladder:
- On a serial link, the PHY generation comes down first, as long as a lower generation exists.
- After that, the UDMA level drops by one per step.
- From UDMA0 the mode moves to PIO4.
- From PIO4 it moves to PIO3, which is the floor.

At the floor the block raises a warning flag and keeps working, but it never steps lower. Every step produces a one-cycle reconfigure request and clears the window. Retraining the link and sending mode-setting commands are left to other logic.

No data flows through the block, so it has no valid/ready interface and nothing can be back-pressured. Every pin is a plain level or pulse. The default configuration is 15 slots of 60 ticks each. With a one-second tick this gives a window of about fifteen minutes.

Top module: `xfer_speed_governor`

## Requirements
- R1: While rst_n is low, the outputs take the initial mode inputs and reconf_req is 0. floor_warn is 1 only if the initial mode is already at the floor. The encoding is: generation 1..3 on a 2-bit field, dma = 1 for UDMA and 0 for PIO, and level 0..6 on a 3-bit field.
- R2: A downgrade happens only when the windowed error count goes above THRESH (default 3), that is, on the (THRESH+1)th counted error. THRESH errors cause no change.
- R3: The window advances one slot every TICKS_PER_SLOT ticks and holds NUM_SLOTS slots. Errors count toward the total no matter which live slot holds them. The errors in a slot are dropped once NUM_SLOTS further slot advances have happened.
- R4: When is_sata is 1 and the generation is above 1, a downgrade lowers the generation by one and leaves the transfer mode unchanged.
- R5: When the generation cannot be lowered and the mode is UDMA with level above 0, a downgrade lowers the UDMA level by one.
- R6: A downgrade from UDMA0 switches the mode to PIO4.
- R7: In PIO above level 3, a downgrade lowers the PIO level by one. At PIO3, floor_warn is 1. Further over-threshold events change no output and produce no reconf_req.
- R8: reconf_req is high for exactly one cycle, in the first cycle that shows the new mode. Each downgrade empties the window, so the next step needs THRESH+1 fresh errors. An error that arrives in the same cycle as a downgrade is dropped.
- R9: When is_sata is 0, the generation output never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; loads the initial mode |
| tick | input | 1 | Slow timebase pulse, one cycle wide |
| err_pulse | input | 1 | One transmission error per cycle high |
| is_sata | input | 1 | 1: serial link, so the PHY generation step is allowed |
| init_gen | input | 2 | Generation loaded at reset (1..3) |
| init_dma | input | 1 | Mode family loaded at reset (1 UDMA, 0 PIO) |
| init_lvl | input | 3 | Mode level loaded at reset |
| cur_gen | output | 2 | Current PHY generation |
| cur_dma | output | 1 | Current mode family |
| cur_lvl | output | 3 | Current mode level |
| reconf_req | output | 1 | One-cycle request to renegotiate |
| floor_warn | output | 1 | Mode is at the PIO floor |

## Verification
The bench walks the full ladder from the top serial generation and UDMA6 down to PIO3. At every rung it checks that exactly THRESH+1 errors cause a step. A design that kept the window after a step would drop several rungs in a row. A design with an off-by-one in the threshold would step on the THRESH-th error.

Ageing is checked on both sides of the window edge:
- Errors one slot short of expiry must still count.
- Errors exactly NUM_SLOTS advances old must be gone.
- Errors spread across several slots must add up.

A design that reset the whole window at a fixed boundary, or never aged errors out, fails one of these three cases. The bench also checks the following:
- The UDMA0 to PIO4 crossing, which a plain decrement would turn into PIO7.
- The floor, where a design that kept stepping would pulse reconf_req or go below PIO3.
- A parallel link, where the generation must never move.

// File: rtl/xsg_pkg.sv
package xsg_pkg;
  typedef struct packed {
    logic [1:0] gen;
    logic       dma;
    logic [2:0] lvl;
  } xfer_mode_t;

  typedef enum logic [2:0] {
    STEP_PHY  = 3'd0,
    STEP_UDMA = 3'd1,
    STEP_XPIO = 3'd2,
    STEP_PIO  = 3'd3,
    STEP_NONE = 3'd4
  } step_kind_e;
endpackage

// File: rtl/xsg_slot_timer.sv
module xsg_slot_timer #(
  parameter int TICKS_PER_SLOT = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic slot_adv
);
  generate
    if (TICKS_PER_SLOT <= 1) begin : g_direct
      assign slot_adv = tick;
    end else begin : g_div
      localparam int TW = $clog2(TICKS_PER_SLOT);
      localparam logic [TW-1:0] LAST = TW'(TICKS_PER_SLOT - 1);
      logic [TW-1:0] tcnt_q;
      assign slot_adv = tick && (tcnt_q == LAST);
      always_ff @(posedge clk) begin
        if (!rst_n)        tcnt_q <= '0;
        else if (slot_adv) tcnt_q <= '0;
        else if (tick)     tcnt_q <= tcnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/xsg_err_window.sv
module xsg_err_window #(
  parameter int NUM_SLOTS = 15,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slot_adv,
  input  logic             err,
  input  logic             clr,
  output logic [CNT_W-1:0] total
);
  localparam int PW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [PW-1:0] LAST = PW'(NUM_SLOTS - 1);

  logic [CNT_W-1:0] slot_q [NUM_SLOTS];
  logic [PW-1:0]    ptr_q, nxt_ptr;
  logic [CNT_W-1:0] total_q, total_d, inc, aged;

  assign inc     = {{(CNT_W-1){1'b0}}, err};
  assign nxt_ptr = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  assign aged    = slot_q[nxt_ptr];
  assign total   = total_q;

  always_comb begin
    if (slot_adv) total_d = total_q - aged + inc;
    else          total_d = total_q + inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      total_q <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= '0;
    end else if (clr) begin
      total_q <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) slot_q[i] <= '0;
    end else begin
      if (slot_adv) begin
        ptr_q           <= nxt_ptr;
        slot_q[nxt_ptr] <= inc;
      end else begin
        slot_q[ptr_q] <= slot_q[ptr_q] + inc;
      end
      total_q <= total_d;
    end
  end
endmodule

// File: rtl/xsg_ladder.sv
module xsg_ladder
  import xsg_pkg::*;
#(
  parameter int MIN_GEN   = 1,
  parameter int PIO_ENTRY = 4,
  parameter int PIO_FLOOR = 3
) (
  input  xfer_mode_t cur,
  input  logic       is_sata,
  output xfer_mode_t nxt,
  output step_kind_e kind,
  output logic       cur_floor,
  output logic       nxt_floor
);
  function automatic logic at_floor(input xfer_mode_t m);
    return !m.dma && (m.lvl <= 3'(PIO_FLOOR));
  endfunction

  always_comb begin
    nxt = cur;
    if (is_sata && (cur.gen > 2'(MIN_GEN))) begin
      kind    = STEP_PHY;
      nxt.gen = cur.gen - 2'd1;
    end else if (cur.dma && (cur.lvl != 3'd0)) begin
      kind    = STEP_UDMA;
      nxt.lvl = cur.lvl - 3'd1;
    end else if (cur.dma) begin
      kind    = STEP_XPIO;
      nxt.dma = 1'b0;
      nxt.lvl = 3'(PIO_ENTRY);
    end else if (!at_floor(cur)) begin
      kind    = STEP_PIO;
      nxt.lvl = cur.lvl - 3'd1;
    end else begin
      kind = STEP_NONE;
    end
  end

  assign cur_floor = at_floor(cur);
  assign nxt_floor = at_floor(nxt);
endmodule

// File: rtl/xfer_speed_governor.sv
module xfer_speed_governor
  import xsg_pkg::*;
#(
  parameter int THRESH         = 3,
  parameter int NUM_SLOTS      = 15,
  parameter int TICKS_PER_SLOT = 60,
  parameter int MIN_GEN        = 1,
  parameter int PIO_ENTRY      = 4,
  parameter int PIO_FLOOR      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       err_pulse,
  input  logic       is_sata,
  input  logic [1:0] init_gen,
  input  logic       init_dma,
  input  logic [2:0] init_lvl,
  output logic [1:0] cur_gen,
  output logic       cur_dma,
  output logic [2:0] cur_lvl,
  output logic       reconf_req,
  output logic       floor_warn
);
  localparam int CNT_W = $clog2(THRESH + 2);

  xfer_mode_t       mode_q, mode_nxt, mode_init;
  step_kind_e       kind;
  logic             slot_adv, over, floor_now, floor_nxt, init_floor;
  logic [CNT_W-1:0] total;
  logic             reconf_q, floor_q;

  assign mode_init = '{gen: init_gen, dma: init_dma, lvl: init_lvl};
  assign init_floor = !init_dma && (init_lvl <= 3'(PIO_FLOOR));

  xsg_slot_timer #(.TICKS_PER_SLOT(TICKS_PER_SLOT)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .slot_adv(slot_adv)
  );

  xsg_err_window #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_window (
    .clk(clk), .rst_n(rst_n), .slot_adv(slot_adv), .err(err_pulse),
    .clr(over), .total(total)
  );

  xsg_ladder #(.MIN_GEN(MIN_GEN), .PIO_ENTRY(PIO_ENTRY), .PIO_FLOOR(PIO_FLOOR)) u_ladder (
    .cur(mode_q), .is_sata(is_sata), .nxt(mode_nxt), .kind(kind),
    .cur_floor(floor_now), .nxt_floor(floor_nxt)
  );

  assign over = (total > CNT_W'(THRESH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= mode_init;
      reconf_q <= 1'b0;
      floor_q  <= init_floor;
    end else begin
      reconf_q <= 1'b0;
      if (over && (kind != STEP_NONE)) begin
        mode_q   <= mode_nxt;
        reconf_q <= 1'b1;
        floor_q  <= floor_nxt;
      end else begin
        floor_q  <= floor_now;
      end
    end
  end

  assign cur_gen    = mode_q.gen;
  assign cur_dma    = mode_q.dma;
  assign cur_lvl    = mode_q.lvl;
  assign reconf_req = reconf_q;
  assign floor_warn = floor_q;
endmodule

// File: rtl/xsg_checker.sv
module xsg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       is_sata,
  input logic [1:0] cur_gen,
  input logic       cur_dma,
  input logic [2:0] cur_lvl,
  input logic       reconf_req,
  input logic       floor_warn
);
  // R8: request is a single-cycle pulse
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_req |=> !reconf_req);

  // R8: request marks a cycle where the mode differs from the previous one
  assert_pulse_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_req |-> ({cur_gen, cur_dma, cur_lvl} != $past({cur_gen, cur_dma, cur_lvl})));

  // R8: mode only moves together with a request
  assert_quiet_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !reconf_req |-> $stable({cur_gen, cur_dma, cur_lvl}));

  // R9: parallel link never moves the generation
  assert_pata_gen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_sata && reconf_req) |-> (cur_gen == $past(cur_gen)));

  // R7: the floor warning is sticky
  assert_floor_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    floor_warn |=> floor_warn);

  // R4: generation never rises
  assert_gen_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reconf_req |-> (cur_gen <= $past(cur_gen)));
endmodule

bind xfer_speed_governor xsg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .is_sata(is_sata), .cur_gen(cur_gen),
  .cur_dma(cur_dma), .cur_lvl(cur_lvl), .reconf_req(reconf_req),
  .floor_warn(floor_warn)
);

// File: tb/xfer_speed_governor_tb.sv
module xfer_speed_governor_tb;
  localparam int TH = 3;
  localparam int NS = 4;
  localparam int TP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, err_pulse = 1'b0, is_sata = 1'b1;
  logic [1:0] init_gen = 2'd3;
  logic init_dma = 1'b1;
  logic [2:0] init_lvl = 3'd6;
  logic [1:0] cur_gen;
  logic cur_dma, reconf_req, floor_warn;
  logic [2:0] cur_lvl;

  int vecs = 0, bad = 0, pulses = 0;
  logic [1:0] e_gen;
  logic e_dma;
  logic [2:0] e_lvl;

  always #5 clk = ~clk;

  xfer_speed_governor #(.THRESH(TH), .NUM_SLOTS(NS), .TICKS_PER_SLOT(TP)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .err_pulse(err_pulse),
    .is_sata(is_sata), .init_gen(init_gen), .init_dma(init_dma),
    .init_lvl(init_lvl), .cur_gen(cur_gen), .cur_dma(cur_dma),
    .cur_lvl(cur_lvl), .reconf_req(reconf_req), .floor_warn(floor_warn)
  );

  always @(negedge clk) if (rst_n && reconf_req) pulses++;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_mode(input string tag);
    logic fl;
    fl = !e_dma && (e_lvl <= 3'd3);
    check(tag, {9'd0, cur_gen, cur_dma, cur_lvl, floor_warn},
               {9'd0, e_gen, e_dma, e_lvl, fl});
  endtask

  task automatic do_reset(input logic s, input logic [1:0] g, input logic d, input logic [2:0] l);
    @(negedge clk);
    rst_n = 1'b0; is_sata = s; init_gen = g; init_dma = d; init_lvl = l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    e_gen = g; e_dma = d; e_lvl = l;
  endtask

  task automatic send_err();
    @(negedge clk) err_pulse = 1'b1;
    @(negedge clk) err_pulse = 1'b0;
  endtask

  task automatic send_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  // expected ladder step computed from R4..R7
  task automatic model_step();
    if (is_sata && e_gen > 2'd1) e_gen = e_gen - 2'd1;
    else if (e_dma && e_lvl != 3'd0) e_lvl = e_lvl - 3'd1;
    else if (e_dma) begin e_dma = 1'b0; e_lvl = 3'd4; end
    else if (e_lvl > 3'd3) e_lvl = e_lvl - 3'd1;
  endtask

  // burst of TH+1 errors; expect one step, checked on the pulse cycle and after
  task automatic step_and_check(input string tag);
    int p0;
    p0 = pulses;
    for (int i = 0; i < TH; i++) send_err();
    repeat (3) @(negedge clk);
    check({tag, " R2 no step at threshold"}, 16'(pulses - p0), 16'd0);
    send_err();
    @(negedge clk);
    model_step();
    check({tag, " R8 pulse"}, {15'd0, reconf_req}, 16'd1);
    check_mode(tag);
    @(negedge clk);
    check({tag, " R8 pulse ends"}, {15'd0, reconf_req}, 16'd0);
    check({tag, " R8 one pulse, window cleared"}, 16'(pulses - p0), 16'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int p0;
    // R1 reset state
    do_reset(1'b1, 2'd3, 1'b1, 3'd6);
    @(negedge clk);
    check_mode("R1 reset load");
    check("R1 reconf low", {15'd0, reconf_req}, 16'd0);

    // full ladder sweep: R4 x2, R5 x6, R6, R7
    for (int s = 0; s < 10; s++) begin
      if (s < 2)       step_and_check("R4 phy step");
      else if (s < 8)  step_and_check("R5 udma step");
      else if (s == 8) step_and_check("R6 udma0 to pio4");
      else             step_and_check("R7 pio4 to pio3");
    end
    // R7 floor holds
    p0 = pulses;
    for (int i = 0; i < 3 * (TH + 1); i++) send_err();
    repeat (3) @(negedge clk);
    check("R7 no pulse at floor", 16'(pulses - p0), 16'd0);
    check_mode("R7 floor mode held");

    // R3 expiry: errors aged out after NS advances
    do_reset(1'b1, 2'd3, 1'b1, 3'd6);
    p0 = pulses;
    for (int i = 0; i < TH; i++) send_err();
    send_ticks(NS * TP);
    send_err();
    repeat (3) @(negedge clk);
    check("R3 aged errors dropped", 16'(pulses - p0), 16'd0);
    check_mode("R3 mode unchanged after expiry");

    // R3 one advance short of expiry still counts
    do_reset(1'b1, 2'd3, 1'b1, 3'd6);
    p0 = pulses;
    for (int i = 0; i < TH; i++) send_err();
    send_ticks((NS - 1) * TP);
    send_err();
    repeat (2) @(negedge clk);
    model_step();
    check("R3 live errors still counted", 16'(pulses - p0), 16'd1);
    check_mode("R3 step to gen2");

    // R3 errors spread across slots add up
    do_reset(1'b1, 2'd3, 1'b1, 3'd6);
    p0 = pulses;
    for (int i = 0; i < TH; i++) begin send_err(); send_ticks(TP); end
    send_err();
    repeat (2) @(negedge clk);
    model_step();
    check("R3 spread errors summed", 16'(pulses - p0), 16'd1);
    check_mode("R3 spread step");

    // R9 + R5: parallel link skips PHY step
    do_reset(1'b0, 2'd3, 1'b1, 3'd2);
    @(negedge clk);
    check_mode("R1 pata reset");
    step_and_check("R9 pata udma step");
    check("R9 gen held", {14'd0, cur_gen}, 16'd3);

    // R5: serial at gen1 goes straight to UDMA
    do_reset(1'b1, 2'd1, 1'b1, 3'd3);
    step_and_check("R5 gen1 udma step");

    // R6 from reset at UDMA0, then R7
    do_reset(1'b1, 2'd1, 1'b1, 3'd0);
    step_and_check("R6 udma0 entry");
    step_and_check("R7 to floor");

    // R1: reset already at floor
    do_reset(1'b0, 2'd2, 1'b0, 3'd3);
    @(negedge clk);
    check_mode("R1 floor at reset");

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule